// File: doc/BRIEF.md
# Pipelined Byte-Write Memory Front End

This block is the synchronous front end of a single-port word memory. On each clock edge where the block is selected and awake, it captures an address, a write-lane mask and the write data. Selection requires three chip-enable inputs at their active levels. A write commits the captured data to the lanes that the mask picks, one edge later. A read fetches the addressed word into an output register, so the word appears two edges after the address was sampled. The storage is a small behavioural array, sized for simulation. The address comes from an external burst sequencer.

The data-out bus is modelled as a value, `rdata`, plus a drive flag, `rdata_drive`. A small state machine follows the select pipeline, with the states DRV_OFF, DRV_ARM, DRV_LIVE and DRV_NAP:
- DRV_OFF goes to DRV_ARM on a selected edge.
- DRV_ARM goes to DRV_LIVE on a second selected edge.
- DRV_ARM and DRV_LIVE fall back to DRV_OFF on any unselected edge.
- Any state goes to DRV_NAP while sleep is high.
- DRV_NAP leaves to DRV_ARM (if selected) or to DRV_OFF once sleep drops.

As a result the bus turns on two edges after selection and turns off one edge after deselection. The drive flag also depends on the output enable, which acts without waiting for a clock edge. A sleep input blocks every access and cuts the drive at once.

Top module: `pbw_mem_top`

## Requirements
- R1: When `wr_all` is 1 on a selected edge, all lanes of `addr` are written with `wdata`, whatever `wr_bytes` and `lane_we` are.
- R2: When `wr_all` is 0, lane i (bits [9i+8:9i]: 8 data bits with the parity bit as bit 9i+8) is written only when `wr_bytes` and `lane_we[i]` are both 1. A selected edge whose resulting lane mask is empty is a read.
- R3: The block is selected only when `en_a`=1, `en_b`=1 and `en_c_n`=0. On unselected edges nothing is written and `rdata` keeps its value.
- R4: A read whose address is sampled at edge N presents the word on `rdata` after edge N+1. `rdata` holds its value when no read completes.
- R5: A read issued on the edge after a write to the same address returns the newly written word.
- R6: After a run of unselected edges, `rdata_drive` (with `oe`=1) stays 0 after the first selected edge and becomes 1 after the second consecutive selected edge.
- R7: `rdata_drive` becomes 0 after the first unselected edge.
- R8: `rdata_drive` follows `oe` combinationally, with no clock edge.
- R9: While `sleep` is 1, `rdata_drive` is 0 at once, no write or read takes effect, and `rdata` holds. After `sleep` falls, the drive follows R6 again.
- R10: After reset, `rdata` is 0 and `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request, acts at once |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all | input | 1 | Whole-word write request |
| wr_bytes | input | 1 | Qualifier for per-lane write enables |
| lane_we | input | LANES | Per-lane write enables |
| addr | input | ADDR_W | Word address from the burst sequencer |
| wdata | input | LANES*LANE_W | Write word |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Output register value |
| rdata_drive | output | 1 | Bus drive flag |

## Verification
A wrong lane mask leaves one 9-bit lane holding a stale or foreign value. That error is visible on the read that returns the word two edges later. The sweep covers every lane-enable pattern under both write modes, so a mis-decoded lane cannot hide. A select state machine in the wrong state shows as `rdata_drive` rising one edge early or late, or lingering one edge after deselection. The bench samples the flag after each single edge to catch this. Errors in sleep gating appear as altered words on later reads, or as a drive flag that stays high in the same cycle that sleep rises.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_ARM  = 2'd1,
        DRV_LIVE = 2'd2,
        DRV_NAP  = 2'd3
    } drv_state_e;
endpackage

// File: rtl/pbw_in_stage.sv
module pbw_in_stage #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr_all,
    input  logic                      wr_bytes,
    input  logic [LANES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic                      acc_q,
    output logic                      rd_q,
    output logic [LANES-1:0]          mask_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0] mask_d;

    // Whole-word write wins over the per-lane path.
    always_comb begin
        if (wr_all) begin
            mask_d = '1;
        end else if (wr_bytes) begin
            mask_d = lane_we;
        end else begin
            mask_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= 1'b0;
            rd_q    <= 1'b0;
            mask_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            acc_q <= sel;
            if (sel) begin
                rd_q    <= (mask_d == '0);
                mask_q  <= mask_d;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    AST_WIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_all) |=> (acc_q && !rd_q && (mask_q == {LANES{1'b1}}))); // R1

    AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_all && !wr_bytes) |=> (acc_q && rd_q)); // R2

    AST_ACC_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !acc_q); // R3

    logic unused_width;
    assign unused_width = (WORD_W == 0);
endmodule

// File: rtl/pbw_lane_array.sv
module pbw_lane_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      acc_q,
    input  logic                      rd_q,
    input  logic [LANES-1:0]          mask_q,
    input  logic [ADDR_W-1:0]         addr_q,
    input  logic [LANES*LANE_W-1:0]   wdata_q,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic wr_fire;
    logic rd_fire;

    assign wr_fire = acc_q && !rd_q && !sleep;
    assign rd_fire = acc_q && rd_q && !sleep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (wr_fire && mask_q[g]) begin
                mem[addr_q] <= wdata_q[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else if (rd_fire) begin
                out_q <= mem[addr_q];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_q && rd_q) |=> $stable(rdata)); // R4

    AST_NAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(rdata)); // R9
endmodule

// File: rtl/pbw_drive_fsm.sv
module pbw_drive_fsm
    import pbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic sel,
    input  logic oe,
    output logic drive
);
    drv_state_e state_q;
    drv_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = DRV_NAP;
        end else begin
            unique case (state_q)
                DRV_OFF:  state_d = sel ? DRV_ARM  : DRV_OFF;
                DRV_ARM:  state_d = sel ? DRV_LIVE : DRV_OFF;
                DRV_LIVE: state_d = sel ? DRV_LIVE : DRV_OFF;
                DRV_NAP:  state_d = sel ? DRV_ARM  : DRV_OFF;
                default:  state_d = DRV_OFF;
            endcase
        end
    end

    always_comb begin
        drive = 1'b0;
        unique case (state_q)
            DRV_LIVE: drive = oe && !sleep;
            DRV_OFF, DRV_ARM, DRV_NAP: drive = 1'b0;
            default:  drive = 1'b0;
        endcase
    end

    AST_LIVE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRV_LIVE) |-> ($past(state_q) == DRV_ARM || $past(state_q) == DRV_LIVE)); // R6

    AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state_q != DRV_LIVE)); // R7

    AST_SLEEP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == DRV_NAP)); // R9
endmodule

// File: rtl/pbw_mem_top.sv
module pbw_mem_top #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      en_a,
    input  logic                      en_b,
    input  logic                      en_c_n,
    input  logic                      wr_all,
    input  logic                      wr_bytes,
    input  logic [LANES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      oe,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdata_drive
);
    localparam int WORD_W = LANES * LANE_W;

    logic              sel;
    logic              acc_q;
    logic              rd_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    assign sel = en_a && en_b && !en_c_n && !sleep;

    pbw_in_stage #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) in_i (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .wr_all(wr_all), .wr_bytes(wr_bytes), .lane_we(lane_we),
        .addr(addr), .wdata(wdata),
        .acc_q(acc_q), .rd_q(rd_q), .mask_q(mask_q),
        .addr_q(addr_q), .wdata_q(wdata_q)
    );

    pbw_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) arr_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .acc_q(acc_q), .rd_q(rd_q), .mask_q(mask_q),
        .addr_q(addr_q), .wdata_q(wdata_q), .rdata(rdata)
    );

    pbw_drive_fsm drv_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .sel(sel), .oe(oe), .drive(rdata_drive)
    );

    always_comb begin
        if (rst_n && (sleep || !oe)) begin
            AST_DRIVE_QUIET: assert (!rdata_drive); // R8
        end
    end

    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a || !en_b || en_c_n) |=> ##1 $stable(rdata)); // R3
endmodule

// File: tb/pbw_mem_top_tb_top.sv
module pbw_mem_top_tb_top;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 6;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep = 1'b0;
    logic              en_a = 1'b0, en_b = 1'b0, en_c_n = 1'b1;
    logic              wr_all = 1'b0, wr_bytes = 1'b0;
    logic [LANES-1:0]  lane_we = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic              oe = 1'b1;
    logic [WORD_W-1:0] rdata;
    logic              rdata_drive;

    logic [WORD_W-1:0] shadow [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbw_mem_top #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n),
        .wr_all(wr_all), .wr_bytes(wr_bytes), .lane_we(lane_we),
        .addr(addr), .wdata(wdata), .oe(oe),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic select(input bit on);
        en_a = on; en_b = 1'b1; en_c_n = !on;
    endtask

    function automatic logic [WORD_W-1:0] pat(input int a, input logic [WORD_W-1:0] salt);
        return 36'h9_1234_5678 ^ (WORD_W'(a) * 36'h1_0203_0405) ^ salt;
    endfunction

    // Issue one write and update the shadow by lane.
    task automatic do_write(input int a, input logic [WORD_W-1:0] d, input bit all,
                            input bit bytes, input logic [LANES-1:0] we);
        select(1'b1);
        wr_all = all; wr_bytes = bytes; lane_we = we; addr = ADDR_W'(a); wdata = d;
        for (int i = 0; i < LANES; i++) begin
            if (all || (bytes && we[i])) shadow[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        end
        step();
        wr_all = 1'b0; wr_bytes = 1'b0; lane_we = '0;
    endtask

    // Back-to-back reads of all words; each checked two edges after sampling.
    task automatic sweep_read(input string req);
        select(1'b1);
        wr_all = 1'b0; wr_bytes = 1'b0;
        for (int a = 0; a <= DEPTH; a++) begin
            addr = ADDR_W'(a % DEPTH);
            step();
            if (a > 0) chk(rdata === shadow[a-1], req, rdata, shadow[a-1]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] held;
        // R10: reset state
        select(1'b1);
        repeat (3) @(negedge clk);
        chk(rdata === '0, "R10", rdata, '0);
        chk(rdata_drive === 1'b0, "R10", {35'd0, rdata_drive}, '0);
        rst_n = 1'b1;
        select(1'b0);
        step();

        // R1: whole-word writes, byte controls set to junk
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, '0), 1'b1, a[0], 4'(a));
        sweep_read("R1");

        // R2: per-lane writes over every enable pattern, qualifier on and off
        for (int a = 0; a < 32; a++) do_write(a, pat(a, 36'hF_0F0F_0F0F), 1'b0, a[4], 4'(a));
        // R1: whole-word wins over any lane pattern
        for (int a = 32; a < 48; a++) do_write(a, pat(a, 36'h3_C3C3_C3C3), 1'b1, a[0], 4'(a));
        sweep_read("R2");

        // R5: write then read same address on the next edge
        do_write(7, 36'hA_5A5A_5A5A, 1'b1, 1'b0, '0);
        addr = 7; step();
        step();
        chk(rdata === 36'hA_5A5A_5A5A, "R5", rdata, 36'hA_5A5A_5A5A);

        // R3: deselected write attempts ignored, rdata held
        held = rdata;
        for (int c = 0; c < 3; c++) begin
            en_a = (c != 0); en_b = (c != 1); en_c_n = (c == 2);
            wr_all = 1'b1; addr = 3; wdata = '1;
            step();
            chk(rdata === held, "R3", rdata, held);
        end
        wr_all = 1'b0;
        step();
        chk(rdata === held, "R3", rdata, held);
        select(1'b1); addr = 3; step(); step();
        chk(rdata === shadow[3], "R3", rdata, shadow[3]);

        // R6/R7: drive timing from deselected
        select(1'b0); step(); step();
        chk(rdata_drive === 1'b0, "R7", {35'd0, rdata_drive}, '0);
        select(1'b1); step();
        chk(rdata_drive === 1'b0, "R6", {35'd0, rdata_drive}, '0);
        step();
        chk(rdata_drive === 1'b1, "R6", {35'd0, rdata_drive}, 36'd1);
        // R8: oe acts with no clock edge
        oe = 1'b0; #1;
        chk(rdata_drive === 1'b0, "R8", {35'd0, rdata_drive}, '0);
        oe = 1'b1; #1;
        chk(rdata_drive === 1'b1, "R8", {35'd0, rdata_drive}, 36'd1);
        select(1'b0); step();
        chk(rdata_drive === 1'b0, "R7", {35'd0, rdata_drive}, '0);
        // one selected edge between deselects never drives
        select(1'b1); step();
        select(1'b0); step();
        chk(rdata_drive === 1'b0, "R6", {35'd0, rdata_drive}, '0);

        // R9: sleep
        select(1'b1); step(); step();
        chk(rdata_drive === 1'b1, "R6", {35'd0, rdata_drive}, 36'd1);
        held = rdata;
        sleep = 1'b1; #1;
        chk(rdata_drive === 1'b0, "R9", {35'd0, rdata_drive}, '0);
        wr_all = 1'b1; addr = 9; wdata = '0; step(); step();
        wr_all = 1'b0; addr = 10; step(); step();
        chk(rdata === held, "R9", rdata, held);
        chk(rdata_drive === 1'b0, "R9", {35'd0, rdata_drive}, '0);
        sleep = 1'b0; addr = 9; step();
        chk(rdata_drive === 1'b0, "R9", {35'd0, rdata_drive}, '0);
        step();
        chk(rdata_drive === 1'b1, "R9", {35'd0, rdata_drive}, 36'd1);
        chk(rdata === shadow[9], "R9", rdata, shadow[9]);

        // R4: rdata holds while only writes happen
        held = rdata;
        do_write(20, 36'h1_1111_1111, 1'b1, 1'b0, '0);
        do_write(21, 36'h2_2222_2222, 1'b0, 1'b1, 4'b0101);
        step();
        chk(rdata === held, "R4", rdata, held);
        sweep_read("R4");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule